// File: doc/BRIEF.md
# Fibonacci Nth term sequencer

This block walks the Fibonacci sequence one term per clock cycle. After reset it starts at term zero. On each rising edge it moves one term forward until the number of steps taken equals the unsigned 4-bit index on `idx_i`. It then stops and presents that term on `term_o` for as long as the clock runs. A `done_o` flag tells the consumer that the value shown is the requested term.

Internally, two term registers hold a lagging and a leading value and are fed by one adder. A step counter is compared against the index, and that compare gates the enables of every register. The output is taken from the lagging register. That register starts at zero, so index 0 gives 0 with no special preload of the pair. A new run begins with a new reset. The index must stay constant while a run is in progress.

Top module: `fib_seq`

## Requirements
- R1: While `rst_ni` is low, and after its release before the first rising edge, `term_o` is 0 and `done_o` is 0.
- R2: Before the halt, each rising edge advances the output by one term: after k edges since reset release, with k less than N, `term_o` equals F(k), where F(0)=0, F(1)=1 and F(i)=F(i-1)+F(i-2).
- R3: The block halts after exactly N advance steps. From the Nth edge after reset release, `term_o` equals F(N).
- R4: Once halted, `term_o` keeps the value F(N) unchanged for every further clock edge, including at least 20 further cycles.
- R5: With N = 0, `term_o` stays 0 from reset onward, with no advance step taken.
- R6: `done_o` rises on edge max(N,1) after reset release. For N > 0 this is the same edge on which `term_o` first shows F(N). It then stays high until the next reset.
- R7: All indices up to 15 are exact on the 10-bit output. For N = 15, the output is 610.
- R8: Asserting reset in the middle of a run abandons that run. After release, the block starts again from term 0 with the index then applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_i | input | 4 | Index N of the term to stop on, unsigned |
| term_o | output | 10 | Current term value |
| done_o | output | 1 | High once the requested term is being held |

## Verification
The bench sweeps every index from 0 to 15 and then random indices. After each edge it compares the output against a bench-computed Fibonacci function. An off-by-one halt would show up as F(N-1) or F(N+1) in place of F(N), and a missing enable gate would let the output run past the target. Index 0 is checked on its own, because a design that preloads the wrong register would show 1 there. A reset in the middle of a run is also checked, because a design with stale term registers or a stale counter would resume from the old position instead of from 0.

// File: rtl/fib_pkg.sv
package fib_pkg;
  parameter int unsigned IDX_W  = 4;
  parameter int unsigned TERM_W = 10;
endpackage

// File: rtl/fib_term_pair.sv
module fib_term_pair #(
  parameter int unsigned TERM_W = fib_pkg::TERM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [TERM_W-1:0] lag_o
);
  logic [TERM_W-1:0] lag_q, lead_q, sum;

  assign sum = lag_q + lead_q;

  // pair (lag, lead) = (F(k), F(k+1)); lag starts at 0 so index 0 needs no preload
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lag_q  <= '0;
      lead_q <= TERM_W'(1);
    end else if (adv_i) begin
      lag_q  <= lead_q;
      lead_q <= sum;
    end
  end

  assign lag_o = lag_q;

  a_r2_advance_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (lead_q == TERM_W'($past(lag_q) + $past(lead_q))) && (lag_q == $past(lead_q)));

  a_r4_hold_when_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(lag_q) && $stable(lead_q));

  a_r7_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> lead_q >= $past(lead_q));
endmodule

// File: rtl/fib_step_ctrl.sv
module fib_step_ctrl #(
  parameter int unsigned IDX_W = fib_pkg::IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  output logic             adv_o,
  output logic             done_o
);
  logic [IDX_W-1:0] cnt_q;
  logic [IDX_W:0]   cnt_inc;
  logic             done_q, done_d;

  assign adv_o   = (cnt_q != idx_i);
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  // done registers on the edge the count lands on idx
  assign done_d  = !adv_o || (cnt_inc == {1'b0, idx_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (adv_o) cnt_q <= cnt_inc[IDX_W-1:0];
      done_q <= done_q | done_d;
    end
  end

  assign done_o = done_q;

  a_r6_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);

  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_o |=> cnt_q == IDX_W'($past(cnt_q) + 1'b1));

  a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= idx_i);

  a_r5_zero_idx_no_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i == '0) |-> !adv_o);

  a_r6_done_means_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !adv_o);
endmodule

// File: rtl/fib_seq.sv
module fib_seq #(
  parameter int unsigned IDX_W  = fib_pkg::IDX_W,
  parameter int unsigned TERM_W = fib_pkg::TERM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [TERM_W-1:0] term_o,
  output logic              done_o
);
  logic adv;

  fib_step_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .idx_i (idx_i),
    .adv_o (adv),
    .done_o(done_o)
  );

  fib_term_pair #(.TERM_W(TERM_W)) u_pair (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (adv),
    .lag_o (term_o)
  );

  a_r4_term_stable_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(term_o));
endmodule

// File: tb/fib_seq_bench.sv
`timescale 1ns/1ps
module fib_seq_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] idx_i = '0;
  logic [9:0] term_o;
  logic       done_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  fib_seq u_fib_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .idx_i (idx_i),
    .term_o(term_o),
    .done_o(done_o)
  );

  function automatic int unsigned fib(input int unsigned k);
    int unsigned a = 0;
    int unsigned b = 1;
    for (int unsigned i = 0; i < k; i++) begin
      int unsigned t = a + b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  task automatic chk(input string req, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic start_run(input int unsigned n);
    @(negedge clk_i);
    rst_ni = 1'b0;
    idx_i  = 4'(n);
    @(negedge clk_i);
    chk("R1 term in reset", term_o, 0);
    chk("R1 done in reset", done_o, 0);
    rst_ni = 1'b1;
    #0.5;
    chk("R1 term after release", term_o, 0);
    chk("R1 done after release", done_o, 0);
  endtask

  task automatic full_run(input int unsigned n);
    int unsigned first_done;
    start_run(n);
    first_done = (n == 0) ? 1 : n;
    for (int unsigned k = 1; k <= n + 20; k++) begin
      int unsigned e;
      @(negedge clk_i);
      e = (k < n) ? fib(k) : fib(n);
      if (n == 0)      chk("R5 zero index term", term_o, 0);
      else if (k < n)  chk("R2 advance", term_o, e);
      else if (k == n) chk("R3 halt term", term_o, e);
      else             chk("R4 hold term", term_o, e);
      chk("R6 done timing", done_o, (k >= first_done) ? 1 : 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_f1b0));
    for (int unsigned n = 0; n < 16; n++) full_run(n);
    chk("R7 F15 value", term_o, 610);
    for (int r = 0; r < 12; r++) full_run($urandom % 16);
    // R8 mid-run reset
    start_run(12);
    repeat (5) @(negedge clk_i);
    chk("R8 mid-run term", term_o, fib(5));
    full_run(7);
    chk("R8 restart result", term_o, 13);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule